// File: doc/BRIEF.md
# Dual-Channel Coherent Downconverter with Integrate-and-Dump Decimation

This block turns two real-valued ADC sample streams into complex baseband and reduces their rate. One 32-bit phase accumulator, stepped by a single tuning word, drives the sine/cosine lookup of both mixers. Both local oscillators therefore share the same phase at every sample, and the two channels stay coherent. Each channel receives a real sample on its in-phase input while its quadrature input is held at zero, so the two mixer products are the sample times the cosine and the sample times the negated sine.

Each of the four mixer products (I and Q for each channel) goes through an integrate-and-dump decimator. On a dump cycle, the decimator keeps the top bits of its accumulator and restarts the sum from the current product. All four results are then sent out on one 16-bit word stream with a valid flag, four words per decimated instant, ready for a receive FIFO. Because each decimated instant needs four output slots, the decimation ratio never drops below 8.

The block runs one input sample per clock on both ADC inputs. A host writes the tuning word and the decimation ratio through two one-cycle write strobes. The `enable` input gates the whole datapath.

Top module: `dual_coherent_ddc`

## Requirements
- R1: A clock edge with `rst_n` low clears `out_valid` and `out_data` to 0, the tuning word to 0 and the decimation ratio to 8.
- R2: A tuning word written with `tune_we` is first added to the shared phase one clock after the write. While `enable` is high, the phase advances by the tuning word on each clock. Both channels mix with this same phase.
- R3: The mixer octant is phase bits [31:29]. Let F = 32767 and D = floor(F*181/256) = 23167. The cosine table for octants 0..7 is F, D, 0, -D, -F, -D, 0, D. The sine table is 0, D, F, D, 0, -D, -F, -D. For a sample x, the mixer gives I = floor(x*cos/32768) and Q = floor(-(x*sin)/32768), each as a 16-bit signed value.
- R4: Channel 1 mixes `adc_a` and channel 2 mixes `adc_b`, each with a zero quadrature input and no input selection. When an ADC input is held at 0, all of that channel's results are 0.
- R5: A decimation ratio written below 8 is stored as 8. Any other value is stored as written.
- R6: Each of the four lanes sums its sign-extended 16-bit mixer product into a 32-bit wrapping accumulator. A dump occurs once every N enabled clocks, where N is the stored ratio. On a dump, accumulator bits [31:16] become the lane's result and the accumulator is reloaded with the current product. The first window after enable holds N-1 products.
- R7: The decimator's result strobe goes high on the clock after a dump. On the clock after the strobe, and the three clocks that follow, `out_valid` is high and `out_data` carries lanes I1, Q1, I2, Q2 in that order.
- R8: Outside these four-word groups, `out_valid` is low and `out_data` is 0.
- R9: `enable` low clears the phase, the mixer products, the accumulators and the results. `out_valid` is low from the second clock after `enable` is first sampled low.
- R10: Two successive groups start at least 8 clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock shared by both ADC inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Datapath run enable; low clears the pipeline |
| adc_a | input | 16 | Signed real sample for channel 1 |
| adc_b | input | 16 | Signed real sample for channel 2 |
| tune_we | input | 1 | Write strobe for the tuning word |
| tune_word | input | 32 | Phase increment per sample |
| rate_we | input | 1 | Write strobe for the decimation ratio |
| rate_word | input | 16 | Requested decimation ratio |
| out_valid | output | 1 | High while an interleaved word is presented |
| out_data | output | 16 | Interleaved word I1, Q1, I2, Q2 |

## Verification
The assertions check the following on every clock: the tuning-word load, the floor on the stored ratio, the zero phase while disabled, zero data whenever valid is low, the four-word limit on a burst, the minimum spacing between group starts, and the quiet output two clocks after enable falls. The exact arithmetic can only be shown by the bench's reference model, run through chosen tuning words and input patterns. That includes the octant lookup, the floor rounding of the mixer products, the short first window, the reload on dump and the lane order.

// File: rtl/ddc_pkg.sv
// Shared widths and the octant coefficient lookup of the dual downconverter.
// Assumes an 8-entry table indexed by the top three phase bits.
package ddc_pkg;

    localparam int PHASE_W  = 32;
    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 16;
    localparam int ACC_W    = 32;
    localparam int RESULT_W = 16;
    localparam int RATE_W   = 16;
    localparam int MIN_RATE = 8;
    localparam int OCT_W    = 3;

    localparam int COEF_FULL = (1 << (COEF_W - 1)) - 1;
    localparam int COEF_DIAG = (COEF_FULL * 181) / 256;

    localparam logic signed [COEF_W-1:0] C_F = COEF_W'(COEF_FULL);
    localparam logic signed [COEF_W-1:0] C_D = COEF_W'(COEF_DIAG);
    localparam logic signed [COEF_W-1:0] C_Z = '0;

    // Cosine of the octant centre-free grid: k * 45 degrees.
    function automatic logic signed [COEF_W-1:0] cos_of(input logic [OCT_W-1:0] oct);
        case (oct)
            3'd0:    return C_F;
            3'd1:    return C_D;
            3'd2:    return C_Z;
            3'd3:    return -C_D;
            3'd4:    return -C_F;
            3'd5:    return -C_D;
            3'd6:    return C_Z;
            default: return C_D;
        endcase
    endfunction

    // Sine on the same grid.
    function automatic logic signed [COEF_W-1:0] sin_of(input logic [OCT_W-1:0] oct);
        case (oct)
            3'd0:    return C_Z;
            3'd1:    return C_D;
            3'd2:    return C_F;
            3'd3:    return C_D;
            3'd4:    return C_Z;
            3'd5:    return -C_D;
            3'd6:    return -C_F;
            default: return -C_D;
        endcase
    endfunction

endpackage

// File: rtl/ddc_mixer.sv
// Real-input mixer: multiplies one sample by cosine and by negated sine of
// the shared phase octant and registers both products scaled back to the
// sample width (floor rounding). Assumes the quadrature input is zero.
module ddc_mixer
    import ddc_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic [OCT_W-1:0]           octant,
    output logic signed [SAMPLE_W-1:0] i_out,
    output logic signed [SAMPLE_W-1:0] q_out
);

    localparam int PROD_W = SAMPLE_W + COEF_W;

    logic signed [PROD_W-1:0] s_ext;
    logic signed [PROD_W-1:0] c_ext;
    logic signed [PROD_W-1:0] n_ext;
    logic signed [PROD_W-1:0] prod_i;
    logic signed [PROD_W-1:0] prod_q;

    // Sign-extend operands and form the two full-precision products.
    always_comb begin
        s_ext  = PROD_W'(sample);
        c_ext  = PROD_W'(cos_of(octant));
        n_ext  = PROD_W'(sin_of(octant));
        prod_i = s_ext * c_ext;
        prod_q = -(s_ext * n_ext);
    end

    // Register the products rescaled by the coefficient full-scale.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            i_out <= '0;
            q_out <= '0;
        end else begin
            i_out <= SAMPLE_W'(prod_i >>> (COEF_W - 1));
            q_out <= SAMPLE_W'(prod_q >>> (COEF_W - 1));
        end
    end

endmodule

// File: rtl/ddc_dump_ctrl.sv
// Decimation control: holds the clamped decimation ratio, counts enabled
// samples and raises a dump once per ratio, plus a strobe one clock later.
// Assumes ratio writes may arrive at any time; a window ends as soon as the
// count reaches the current ratio.
module ddc_dump_ctrl #(
    parameter int RATE_W   = 16,
    parameter int MIN_RATE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_word,
    output logic [RATE_W-1:0] rate_q,
    output logic              dump,
    output logic              strobe
);

    localparam logic [RATE_W-1:0] FLOOR = RATE_W'(MIN_RATE);

    logic [RATE_W-1:0] cnt;

    // Ratio register with the lower floor applied on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rate_q <= FLOOR;
        else if (rate_we)
            rate_q <= (rate_word < FLOOR) ? FLOOR : rate_word;
    end

    // Dump decision for the current sample.
    always_comb dump = run && (cnt >= rate_q - RATE_W'(1));

    // Sample counter and delayed result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else begin
            cnt    <= dump ? '0 : cnt + RATE_W'(1);
            strobe <= dump;
        end
    end

endmodule

// File: rtl/ddc_int_dump.sv
// Integrate-and-dump lane: accumulates sign-extended products; on dump it
// keeps the top result bits and reloads with the current product.
// Assumes ACC_W >= IN_W and ACC_W >= OUT_W.
module ddc_int_dump #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 32,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    dump,
    input  logic signed [IN_W-1:0]  din,
    output logic [OUT_W-1:0]        result
);

    logic [ACC_W-1:0] din_ext;
    logic [ACC_W-1:0] acc;

    // Sign extension of the lane input.
    always_comb din_ext = ACC_W'(din);

    // Accumulate, or dump and restart from the current product.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            acc    <= '0;
            result <= '0;
        end else if (dump) begin
            result <= acc[ACC_W-1 -: OUT_W];
            acc    <= din_ext;
        end else begin
            acc    <= acc + din_ext;
        end
    end

endmodule

// File: rtl/ddc_interleave.sv
// Output interleaver: on a start pulse emits all lanes on consecutive clocks
// in lane order with valid high; output is zero while idle.
// Assumes starts are spaced further apart than LANES clocks.
module ddc_interleave #(
    parameter int W     = 16,
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    start,
    input  logic [LANES-1:0][W-1:0] lanes,
    output logic                    valid,
    output logic [W-1:0]            data
);

    localparam int SLOT_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(LANES - 1);

    logic [SLOT_W-1:0] slot;
    logic              busy;

    // Walk the lanes once per start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            valid <= 1'b0;
            data  <= '0;
            slot  <= '0;
            busy  <= 1'b0;
        end else if (start) begin
            valid <= 1'b1;
            data  <= lanes[0];
            slot  <= SLOT_W'(1);
            busy  <= (LANES > 1);
        end else if (busy) begin
            valid <= 1'b1;
            data  <= lanes[slot];
            slot  <= slot + SLOT_W'(1);
            busy  <= (slot != LAST);
        end else begin
            valid <= 1'b0;
            data  <= '0;
        end
    end

endmodule

// File: rtl/dual_coherent_ddc.sv
// Two-channel coherent downconverter: one phase accumulator feeds two real
// mixers, four integrate-and-dump lanes decimate the products and an
// interleaver streams I1, Q1, I2, Q2 per decimated instant.
// Assumes one sample per clock on both ADC inputs.
module dual_coherent_ddc
    import ddc_pkg::*;
#(
    parameter int P_PHASE_W  = ddc_pkg::PHASE_W,
    parameter int P_SAMPLE_W = ddc_pkg::SAMPLE_W,
    parameter int P_ACC_W    = ddc_pkg::ACC_W,
    parameter int P_RESULT_W = ddc_pkg::RESULT_W,
    parameter int P_RATE_W   = ddc_pkg::RATE_W,
    parameter int P_MIN_RATE = ddc_pkg::MIN_RATE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [P_SAMPLE_W-1:0] adc_a,
    input  logic [P_SAMPLE_W-1:0] adc_b,
    input  logic                  tune_we,
    input  logic [P_PHASE_W-1:0]  tune_word,
    input  logic                  rate_we,
    input  logic [P_RATE_W-1:0]   rate_word,
    output logic                  out_valid,
    output logic [P_RESULT_W-1:0] out_data
);

    localparam int NUM_CH = 2;
    localparam int LANES  = 2 * NUM_CH;

    logic [P_PHASE_W-1:0]                   tune_q;
    logic [P_PHASE_W-1:0]                   phase_q;
    logic                                   run_q;
    logic [OCT_W-1:0]                       octant;
    logic [NUM_CH-1:0][P_SAMPLE_W-1:0]      ch_in;
    logic [LANES-1:0][P_SAMPLE_W-1:0]       mix_lane;
    logic [LANES-1:0][P_RESULT_W-1:0]       res_lane;
    logic [P_RATE_W-1:0]                    rate_q;
    logic                                   dump;
    logic                                   strobe;

    // Tuning word register, applied from the clock after a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tune_q <= '0;
        else if (tune_we)
            tune_q <= tune_word;
    end

    // Shared phase accumulator, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            phase_q <= '0;
        else
            phase_q <= phase_q + tune_q;
    end

    // Enable delayed to line up with the registered mixer products.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else
            run_q <= enable;
    end

    // Fixed channel inputs and the shared lookup index.
    always_comb begin
        ch_in[0] = adc_a;
        ch_in[1] = adc_b;
        octant   = phase_q[P_PHASE_W-1 -: OCT_W];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ddc_mixer #(
            .SAMPLE_W (P_SAMPLE_W)
        ) u_mixer (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (enable),
            .sample (ch_in[c]),
            .octant (octant),
            .i_out  (mix_lane[2*c]),
            .q_out  (mix_lane[2*c+1])
        );
    end

    ddc_dump_ctrl #(
        .RATE_W   (P_RATE_W),
        .MIN_RATE (P_MIN_RATE)
    ) u_dump_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .rate_we   (rate_we),
        .rate_word (rate_word),
        .rate_q    (rate_q),
        .dump      (dump),
        .strobe    (strobe)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ddc_int_dump #(
            .IN_W  (P_SAMPLE_W),
            .ACC_W (P_ACC_W),
            .OUT_W (P_RESULT_W)
        ) u_int_dump (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_q),
            .dump   (dump),
            .din    (mix_lane[l]),
            .result (res_lane[l])
        );
    end

    ddc_interleave #(
        .W     (P_RESULT_W),
        .LANES (LANES)
    ) u_interleave (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .start (strobe),
        .lanes (res_lane),
        .valid (out_valid),
        .data  (out_data)
    );

endmodule

// File: rtl/ddc_checker.sv
// Property checker for the dual downconverter, bound to the top module.
// Watches ports plus the tuning, phase and ratio registers.
module ddc_checker #(
    parameter int PHASE_W  = 32,
    parameter int RESULT_W = 16,
    parameter int RATE_W   = 16,
    parameter int MIN_RATE = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                tune_we,
    input logic [PHASE_W-1:0]  tune_word,
    input logic [PHASE_W-1:0]  tune_q,
    input logic [PHASE_W-1:0]  phase_q,
    input logic [RATE_W-1:0]   rate_q,
    input logic                out_valid,
    input logic [RESULT_W-1:0] out_data
);

    logic [2:0] run_len;
    logic [7:0] gap;
    logic       prev_valid;

    // Length of the current valid burst and clocks since the last group start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len    <= '0;
            gap        <= 8'hFF;
            prev_valid <= 1'b0;
        end else begin
            run_len    <= out_valid ? ((run_len == 3'd7) ? run_len : run_len + 3'd1) : 3'd0;
            gap        <= (out_valid && !prev_valid) ? 8'd1 : ((gap == 8'hFF) ? gap : gap + 8'd1);
            prev_valid <= out_valid;
        end
    end

    // R2
    tune_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tune_we)) |-> tune_q == $past(tune_word));

    // R5
    rate_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_q >= RATE_W'(MIN_RATE));

    // R9
    phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(enable)) |-> phase_q == '0);

    // R9
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable, 2) |-> !out_valid);

    // R8
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_data == '0);

    // R7
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> run_len < 3'd4);

    // R10
    group_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> gap >= 8'(MIN_RATE));

endmodule

bind dual_coherent_ddc ddc_checker #(
    .PHASE_W  (P_PHASE_W),
    .RESULT_W (P_RESULT_W),
    .RATE_W   (P_RATE_W),
    .MIN_RATE (P_MIN_RATE)
) u_ddc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tune_we   (tune_we),
    .tune_word (tune_word),
    .tune_q    (tune_q),
    .phase_q   (phase_q),
    .rate_q    (rate_q),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/test_dual_coherent_ddc.sv
// Bench: behavioural reference model compared with the design on every clock.
module test_dual_coherent_ddc;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] adc_a = '0;
    logic [15:0] adc_b = '0;
    logic        tune_we = 1'b0;
    logic [31:0] tune_word = '0;
    logic        rate_we = 1'b0;
    logic [15:0] rate_word = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int fails  = 0;
    int cyc_no = 0;
    bit done   = 0;
    string tag = "R1";

    // model state
    longint m_tune, m_phase, m_acc[4];
    int     m_rate, m_cnt, m_mix[4], m_res[4];
    bit     m_en_d, m_stb, m_ov;
    int     m_od;
    int     wq[$];

    // observation of group starts
    bit prev_ov = 0;
    int last_rise = -1;
    int gaps[$];

    always #(CLK_P/2) clk = ~clk;

    dual_coherent_ddc i_dual_coherent_ddc (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .adc_a(adc_a), .adc_b(adc_b),
        .tune_we(tune_we), .tune_word(tune_word),
        .rate_we(rate_we), .rate_word(rate_word),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int cosv(int oct);
        int f = 32767; int d = (32767 * 181) / 256;
        int t[8] = '{f, d, 0, -d, -f, -d, 0, d};
        return t[oct];
    endfunction

    function automatic int sinv(int oct);
        int f = 32767; int d = (32767 * 181) / 256;
        int t[8] = '{0, d, f, d, 0, -d, -f, -d};
        return t[oct];
    endfunction

    function automatic int scale(longint p);
        longint s = p >>> 15;
        return int'(shortint'(s));
    endfunction

    // One clock edge of the reference model, later stages first.
    task automatic model_edge();
        int xa, xb, oct;
        bit dmp;
        if (!rst_n) begin
            m_tune = 0; m_phase = 0; m_rate = 8; m_cnt = 0;
            m_en_d = 0; m_stb = 0; m_ov = 0; m_od = 0; wq.delete();
            for (int k = 0; k < 4; k++) begin m_acc[k] = 0; m_mix[k] = 0; m_res[k] = 0; end
            return;
        end
        if (!m_en_d) begin
            wq.delete(); m_ov = 0; m_od = 0;
        end else begin
            if (m_stb) for (int k = 0; k < 4; k++) wq.push_back(m_res[k]);
            if (wq.size() > 0) begin m_od = wq.pop_front(); m_ov = 1; end
            else begin m_ov = 0; m_od = 0; end
        end
        if (!m_en_d) begin
            m_cnt = 0; m_stb = 0;
            for (int k = 0; k < 4; k++) begin m_acc[k] = 0; m_res[k] = 0; end
        end else begin
            dmp = (m_cnt >= m_rate - 1);
            m_stb = dmp;
            for (int k = 0; k < 4; k++) begin
                if (dmp) begin
                    m_res[k] = int'((m_acc[k] >> 16) & 64'hFFFF);
                    m_acc[k] = longint'(m_mix[k]) & 64'hFFFF_FFFF;
                end else begin
                    m_acc[k] = (m_acc[k] + longint'(m_mix[k])) & 64'hFFFF_FFFF;
                end
            end
            m_cnt = dmp ? 0 : m_cnt + 1;
        end
        if (!enable) begin
            m_phase = 0;
            for (int k = 0; k < 4; k++) m_mix[k] = 0;
        end else begin
            oct = int'(m_phase >> 29);
            xa = int'($signed(adc_a));
            xb = int'($signed(adc_b));
            m_mix[0] = scale(longint'(xa) * cosv(oct));
            m_mix[1] = scale(-(longint'(xa) * sinv(oct)));
            m_mix[2] = scale(longint'(xb) * cosv(oct));
            m_mix[3] = scale(-(longint'(xb) * sinv(oct)));
            m_phase = (m_phase + m_tune) & 64'hFFFF_FFFF;
        end
        m_en_d = enable;
        if (tune_we) m_tune = longint'(tune_word);
        if (rate_we) m_rate = (int'(rate_word) < 8) ? 8 : int'(rate_word);
    endtask

    task automatic check(bit ok, string req, string what, int got, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, got, exp, cyc_no);
        end
    endtask

    // Advance one clock, update the model, compare at the falling edge.
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc_no++;
        check(out_valid == m_ov, tag, "out_valid", int'(out_valid), int'(m_ov));
        check(int'(out_data) == m_od, tag, "out_data", int'(out_data), m_od);
        if (out_valid && !prev_ov) begin
            if (last_rise >= 0) gaps.push_back(cyc_no - last_rise);
            last_rise = cyc_no;
        end
        prev_ov = out_valid;
        tune_we = 0;
        rate_we = 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic check_gaps(string req, int exp);
        check(gaps.size() > 0, req, "group starts seen", gaps.size(), 1);
        foreach (gaps[i]) check(gaps[i] == exp, req, "group spacing", gaps[i], exp);
        gaps.delete();
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        tune_word = 32'h1234_5678; rate_word = 16'd3;
        run(3);
        check(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
        check(out_data == 16'd0, "R1", "reset out_data", int'(out_data), 0);
        rst_n = 1;

        // R8: idle while disabled, inputs moving
        tag = "R8";
        for (int i = 0; i < 12; i++) begin adc_a = 16'($urandom); adc_b = 16'($urandom); cyc(); end

        // R6: zero tuning, default ratio, constant inputs of both signs
        tag = "R6";
        adc_a = 16'sd30000; adc_b = -16'sd25000; enable = 1;
        run(60);

        // R7: lane order with distinct channel contents
        tag = "R7";
        for (int i = 0; i < 48; i++) begin adc_a = 16'(i * 1500 - 20000); adc_b = 16'(9000 - i * 700); cyc(); end

        // R2: new tuning word mid-stream
        tag = "R2";
        tune_word = 32'h1000_0000; tune_we = 1;
        run(50);

        // R3: one octant per sample, full-scale ramp including the negative extreme
        tag = "R3";
        tune_word = 32'h2000_0000; tune_we = 1;
        for (int i = 0; i < 80; i++) begin adc_a = (i % 9 == 0) ? 16'h8000 : 16'(32767 - i * 600); adc_b = 16'(i * 411); cyc(); end

        // R4: channel 2 input held at zero
        tag = "R4";
        adc_b = 0;
        for (int i = 0; i < 40; i++) begin adc_a = 16'($urandom); cyc(); end
        adc_b = 16'sd4000; adc_a = 0;
        run(40);

        // R5 / R10: ratio below the floor behaves as 8
        tag = "R5";
        rate_word = 16'd3; rate_we = 1;
        run(10);
        gaps.delete();
        for (int i = 0; i < 60; i++) begin adc_a = 16'($urandom); adc_b = 16'($urandom); cyc(); end
        check_gaps("R5", 8);
        tag = "R10";
        rate_word = 16'd0; rate_we = 1;
        run(12);
        gaps.delete();
        run(40);
        check_gaps("R10", 8);

        // R6: longer ratio
        tag = "R6";
        rate_word = 16'd20; rate_we = 1;
        run(25);
        gaps.delete();
        for (int i = 0; i < 100; i++) begin adc_a = 16'($urandom); adc_b = 16'($urandom); cyc(); end
        check_gaps("R6", 20);

        // R9: enable dropped inside a group
        tag = "R9";
        rate_word = 16'd8; rate_we = 1;
        run(30);
        while (!out_valid) cyc();
        enable = 0;
        cyc();
        cyc();
        check(out_valid == 1'b0, "R9", "valid two clocks after disable", int'(out_valid), 0);
        run(4);
        enable = 1;
        for (int i = 0; i < 60; i++) begin adc_a = 16'($urandom); adc_b = 16'($urandom); cyc(); end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule